// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Byte Service Key

This block is a watchdog counter driven by its own watchdog clock. Software enables it by writing a nonzero rate code into a small control register. From then on it must keep servicing the block by writing a two-byte key into a separate service register. If the key does not arrive before the selected time-out, the block pulses a system reset request.

Two further controls exist. An optional window mode accepts service writes only in the final quarter of each period. A debug-freeze bit stops the counter while a debugger holds the device. When the device is in special mode with debug active and freezing off, an override replaces the programmed rate and the window setting with the longest period. A mask bit in a control write lets the freeze bit be changed without disturbing the rate or the window setting.

The control and service writes are single-cycle strobes in the watchdog clock domain. The reset request is a registered one-cycle pulse that feeds the chip's reset controller.

Top module: `wdog_window`

## Requirements
- R1: Out of reset the rate code is 000 (watchdog disabled), the window and freeze bits are 0, `ctl_rdata` reads 0x00 and `reset_req` is low.
- R2: Rate codes 1 to 7 give periods of 2^(E-RATE_SHIFT) watchdog-clock cycles, where E is 14, 16, 18, 20, 22, 23 and 24 in that order.
- R3: When the counter completes a period without service, `reset_req` is high for exactly the next cycle, the counter returns to zero and a fresh period begins. With rate 1 and RATE_SHIFT 10, the rising edge of `reset_req` comes 16 cycles after the edge that started the period.
- R4: A control write with bit 7 clear loads the rate (bits 2:0) and the window bit (bit 4), and it restarts the period from zero. With rate 000 the counter holds at zero, no request is produced, and service writes have no effect.
- R5: A service write of 0x55 arms the key. A following 0xAA restarts the period with no request. Any number of 0x55 writes may come before the 0xAA.
- R6: While the watchdog is enabled, a service write of any byte other than 0x55 or 0xAA, or a 0xAA that is not armed, gives a reset request on the next cycle and disarms the key.
- R7: In window mode, a service write while the count is below three quarters of the period gives a reset request. Writes at a count of 3P/4 or above are accepted. After a completed restart, the next write is early again until the window reopens.
- R8: With the freeze bit (bit 5) set, the counter holds its value while `dbg_active` is high. With the freeze bit clear, the counter keeps running during debug.
- R9: A control write with bit 7 set leaves the rate and window bits unchanged and the period undisturbed, but it still loads the freeze bit. `ctl_rdata` shows {0, 0, freeze, window, 0, rate[2:0]}, so bit 7 always reads 0.
- R10: While the watchdog is enabled, `dbg_active` and `special_mode` are high and the freeze bit is 0, the period is 2^(24-RATE_SHIFT) cycles and window mode is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: [7] mask, [5] freeze, [4] window, [2:0] rate |
| ctl_rdata | output | 8 | Control register readback |
| svc_wr | input | 1 | Service register write strobe |
| svc_wdata | input | 8 | Service key byte |
| dbg_active | input | 1 | Debug mode is active |
| special_mode | input | 1 | Device is in special mode |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with RATE_SHIFT set to 10. This shrinks the periods to between 16 and 16384 cycles. Every rate therefore times out within a short run, the exact 16-cycle time-out and the 12-count window boundary of rate 1 can be checked directly, and the override's longest period can be measured in full. The random phase mixes rates 0 to 3, key bytes, debug toggles and masked writes. At these short periods, timeouts, window violations and restarts interleave densely.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned LONGEST_EXP = 24;
  localparam logic [7:0]  KEY_ARM     = 8'h55;
  localparam logic [7:0]  KEY_FIRE    = 8'hAA;

  typedef struct packed {
    logic [2:0] rate;
    logic       win;
    logic       frz;
  } wd_cfg_t;

  // period exponent for a rate code; 0 for the disabled code
  function automatic int unsigned rate_exp(input logic [2:0] rate);
    case (rate)
      3'd1:    return 14;
      3'd2:    return 16;
      3'd3:    return 18;
      3'd4:    return 20;
      3'd5:    return 22;
      3'd6:    return 23;
      3'd7:    return 24;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] period_of(input int unsigned e);
    return 32'd1 << e;
  endfunction

  // first count value that falls inside the service window
  function automatic logic [31:0] window_open(input logic [31:0] period);
    return period - (period >> 2);
  endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output wd_cfg_t    cfg,
  output logic       load
);

  assign load = wr & ~wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr) begin
      cfg.frz <= wdata[5];
      if (!wdata[7]) begin
        cfg.rate <= wdata[2:0];
        cfg.win  <= wdata[4];
      end
    end
  end

endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_ok,
  input  logic [7:0] key,
  input  logic       early,
  output logic       restart,
  output logic       violation
);

  logic armed_q;
  logic is_arm, is_fire;

  assign is_arm    = (key == KEY_ARM);
  assign is_fire   = (key == KEY_FIRE);
  assign restart   = svc_ok & ~early & is_fire & armed_q;
  assign violation = svc_ok & (early | ~(is_arm | (is_fire & armed_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   armed_q <= 1'b0;
    else if (violation | restart) armed_q <= 1'b0;
    else if (svc_ok & is_arm)     armed_q <= 1'b1;
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (run)   count <= count + 1'b1;
  end

endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int RATE_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       svc_wr,
  input  logic [7:0] svc_wdata,
  input  logic       dbg_active,
  input  logic       special_mode,
  output logic       reset_req
);

  localparam int CW = LONGEST_EXP - RATE_SHIFT;

  wd_cfg_t     cfg;
  logic        cfg_load;
  logic        enabled, frozen, override_on, run, eff_win;
  logic [31:0] period, win_start;
  logic        early_win, terminal;
  logic        restart_ev, violation_ev, timeout_ev, cnt_clear;
  logic [CW-1:0] count_q;
  logic        req_q;
  int unsigned sel_exp;

  wdog_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .cfg   (cfg),
    .load  (cfg_load)
  );

  assign enabled     = (cfg.rate != 3'd0);
  assign frozen      = dbg_active & cfg.frz;
  assign override_on = enabled & dbg_active & ~cfg.frz & special_mode;
  assign run         = enabled & ~frozen;
  assign eff_win     = cfg.win & ~override_on;

  always_comb begin
    if (override_on)  sel_exp = LONGEST_EXP - RATE_SHIFT;
    else if (enabled) sel_exp = rate_exp(cfg.rate) - RATE_SHIFT;
    else              sel_exp = 1;
  end

  assign period    = period_of(sel_exp);
  assign win_start = window_open(period);
  assign early_win = eff_win & (32'(count_q) < win_start);
  assign terminal  = run & (32'(count_q) >= period - 32'd1);

  wdog_key_seq u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_ok    (svc_wr & enabled),
    .key       (svc_wdata),
    .early     (early_win),
    .restart   (restart_ev),
    .violation (violation_ev)
  );

  assign timeout_ev = terminal & ~restart_ev;
  assign cnt_clear  = cfg_load | restart_ev | violation_ev | timeout_ev | ~enabled;

  wdog_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .run   (run),
    .count (count_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= timeout_ev | violation_ev;
  end

  assign reset_req = req_q;
  assign ctl_rdata = {2'b00, cfg.frz, cfg.win, 1'b0, cfg.rate};

endmodule

module wdog_window_chk #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic [7:0]    ctl_rdata,
  input  logic          svc_wr,
  input  logic [7:0]    svc_wdata,
  input  logic          dbg_active,
  input  logic          reset_req,
  input  logic          enabled,
  input  logic          frz_bit,
  input  logic          early_win,
  input  logic [CW-1:0] count_q
);

  // R3
  req_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (count_q == '0));

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && $past(!enabled)) |-> !reset_req);

  // R6
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && enabled && svc_wdata != 8'h55 && svc_wdata != 8'hAA) |=> reset_req);

  // R7
  early_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && enabled && early_win) |=> reset_req);

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && frz_bit && !ctl_wr && !svc_wr) |=> $stable(count_q));

  // R9
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[7]) |=> $stable({ctl_rdata[4], ctl_rdata[2:0]}));

endmodule

bind wdog_window wdog_window_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .ctl_rdata  (ctl_rdata),
  .svc_wr     (svc_wr),
  .svc_wdata  (svc_wdata),
  .dbg_active (dbg_active),
  .reset_req  (reset_req),
  .enabled    (enabled),
  .frz_bit    (cfg.frz),
  .early_win  (early_win),
  .count_q    (count_q)
);

// File: tb/sim_wdog_window.sv
module sim_wdog_window;

  localparam int CLK_PERIOD = 10;
  localparam int SH         = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       svc_wr = 1'b0;
  logic [7:0] svc_wdata = 8'h00;
  logic       dbg_active = 1'b0;
  logic       special_mode = 1'b0;
  logic       reset_req;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int cycles = 0;
  bit compare_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_window #(.RATE_SHIFT(SH)) u0 (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .ctl_rdata,
    .svc_wr, .svc_wdata, .dbg_active, .special_mode, .reset_req
  );

  // expected period for a rate code, restated from the rate list
  function automatic int exp_for(input int rate);
    if (rate <= 5) return 14 + 2 * (rate - 1);
    return 17 + rate;
  endfunction

  function automatic int cycles_for(input int rate);
    return 1 << (exp_for(rate) - SH);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model, stepped on the same edges as the design
  int       m_rate, m_cnt;
  bit       m_win, m_frz, m_arm, m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rate <= 0; m_win <= 0; m_frz <= 0; m_arm <= 0; m_req <= 0; m_cnt <= 0;
    end else begin
      bit en, ovr, win, run, bad, rst_ok, tmo;
      int per;
      en  = (m_rate != 0);
      ovr = en && dbg_active && !m_frz && special_mode;
      per = ovr ? (1 << (24 - SH)) : (en ? cycles_for(m_rate) : 2);
      win = m_win && !ovr;
      run = en && !(dbg_active && m_frz);
      bad = 0; rst_ok = 0;
      if (svc_wr && en) begin
        if (win && m_cnt * 4 < per * 3) bad = 1;
        else if (svc_wdata == 8'h55) m_arm <= 1;
        else if (svc_wdata == 8'hAA && m_arm) rst_ok = 1;
        else bad = 1;
      end
      tmo = run && (m_cnt >= per - 1) && !rst_ok;
      m_req <= bad | tmo;
      if (bad | rst_ok) m_arm <= 0;
      if (ctl_wr) m_frz <= ctl_wdata[5];
      if (ctl_wr && !ctl_wdata[7]) begin
        m_rate <= int'(ctl_wdata[2:0]);
        m_win  <= ctl_wdata[4];
        m_cnt  <= 0;
      end else if (!en || bad || rst_ok || tmo) m_cnt <= 0;
      else if (run) m_cnt <= m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (reset_req) pulses++;
    if (compare_on) begin
      // R3 request timing against the model
      check(reset_req == m_req, "R3 model reset_req", int'(reset_req), int'(m_req));
      // R9 readback against the model
      check(ctl_rdata == {2'b00, m_frz, m_win, 1'b0, 3'(m_rate)}, "R9 model rdata",
            int'(ctl_rdata), int'({2'b00, m_frz, m_win, 1'b0, 3'(m_rate)}));
    end
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // tasks are entered at a negedge and return at the next one
  task automatic ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic svc(input logic [7:0] v);
    svc_wr = 1'b1; svc_wdata = v;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic wait_rise(output int n, input int lim);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (reset_req) break;
    end
  endtask

  initial begin
    int n, p0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(ctl_rdata == 8'h00, "R1 rdata", int'(ctl_rdata), 0);
    check(reset_req == 1'b0, "R1 reset_req", int'(reset_req), 0);

    // R4 disabled: bad key ignored
    p0 = pulses;
    svc(8'h12);
    repeat (20) @(negedge clk);
    check(pulses == p0, "R4 disabled ignores service", pulses - p0, 0);

    // R2/R3 rate 1 time-out
    ctl(8'h01);
    check(ctl_rdata == 8'h01, "R4 rate load", int'(ctl_rdata), 1);
    wait_rise(n, 100);
    check(n == cycles_for(1), "R2 rate1 period", n, cycles_for(1));
    @(negedge clk);
    check(reset_req == 1'b0, "R3 single pulse", int'(reset_req), 0);
    wait_rise(n, 100);
    check(n == cycles_for(1) - 1, "R3 next period", n, cycles_for(1) - 1);

    // R5 service with repeated arm bytes, rate 2
    ctl(8'h02);
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      repeat (40) @(negedge clk);
      svc(8'h55); svc(8'h55); svc(8'hAA);
    end
    check(pulses == p0, "R5 serviced no request", pulses - p0, 0);
    wait_rise(n, 200);
    check(n == cycles_for(2), "R5 period after restart", n, cycles_for(2));

    // R6 bad keys
    svc(8'h12);
    check(reset_req == 1'b1, "R6 bad byte", int'(reset_req), 1);
    svc(8'hAA);
    check(reset_req == 1'b1, "R6 unarmed AA", int'(reset_req), 1);

    // R7 window mode, rate 1: window opens at count 12
    ctl(8'h11);
    svc(8'h55);
    check(reset_req == 1'b1, "R7 early write", int'(reset_req), 1);
    repeat (11) @(negedge clk);
    svc(8'h55);
    check(reset_req == 1'b1, "R7 count 11 early", int'(reset_req), 1);
    repeat (12) @(negedge clk);
    p0 = pulses;
    svc(8'h55); svc(8'hAA);
    check(pulses == p0, "R7 window accepted", pulses - p0, 0);
    svc(8'h55);
    check(reset_req == 1'b1, "R7 next window closed", int'(reset_req), 1);

    // R8 freeze during debug
    ctl(8'h21);
    dbg_active = 1'b1;
    p0 = pulses;
    repeat (100) @(negedge clk);
    check(pulses == p0, "R8 frozen", pulses - p0, 0);
    dbg_active = 1'b0;
    wait_rise(n, 100);
    check(n == cycles_for(1), "R8 resumes", n, cycles_for(1));

    // R8 no freeze: counts in debug
    ctl(8'h01);
    dbg_active = 1'b1;
    wait_rise(n, 100);
    check(n == cycles_for(1), "R8 runs in debug", n, cycles_for(1));
    dbg_active = 1'b0;

    // R10 override: window ignored, longest period
    ctl(8'h11);
    dbg_active = 1'b1; special_mode = 1'b1;
    p0 = pulses;
    svc(8'h55); svc(8'hAA);
    check(pulses == p0, "R10 window ignored", pulses - p0, 0);
    wait_rise(n, 20000);
    check(n == (1 << (24 - SH)), "R10 longest period", n, 1 << (24 - SH));
    dbg_active = 1'b0; special_mode = 1'b0;

    // R9 masked write
    ctl(8'hA3);
    check(ctl_rdata == 8'h31, "R9 mask keeps rate/window", int'(ctl_rdata), 8'h31);
    ctl(8'h00);
    check(ctl_rdata == 8'h00, "R4 disable", int'(ctl_rdata), 0);

    // random phase against the model
    compare_on = 1'b1;
    for (int c = 0; c < 20000; c++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2) begin
        ctl_wr = 1'b1;
        ctl_wdata = {($urandom % 5 == 0) ? 1'b1 : 1'b0, 1'b0, 1'($urandom), 1'($urandom),
                     1'b0, 3'($urandom % 4)};
      end else if (r < 10) begin
        int k;
        k = int'($urandom % 10);
        svc_wr = 1'b1;
        svc_wdata = (k < 4) ? 8'h55 : (k < 9) ? 8'hAA : 8'($urandom);
      end
      if ($urandom % 100 == 0) dbg_active = ~dbg_active;
      if ($urandom % 100 == 0) special_mode = ~special_mode;
      @(negedge clk);
      ctl_wr = 1'b0; svc_wr = 1'b0;
    end
    compare_on = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule